// File: doc/BRIEF.md
# Symbol-Level Header Prepender

This block places a fixed-length header in front of every frame on a streaming packet interface. The interface carries valid, start-of-packet, end-of-packet, empty and ready signals. The header arrives as a flat vector. The block samples it when a frame's first input word is offered. It then emits the header symbols and follows them at once with the payload symbols, so no unused lanes sit between the two parts.

The header length is a whole number of symbols and does not have to fill a whole number of data words. When the last header word is only partly filled, the payload is shifted across word boundaries. A short remnant is carried from each input word into the next output word. The empty count of the final word is recomputed from the combined length. A matching splitter can then recover the header and the payload exactly.

Backpressure on the output stalls the input. The input ready is also held low in two cases: while whole header words are emitted, and while one extra trailing word is flushed.

Top module: `sym_hdr_prepend`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid and in_ready are both low.
- R2: Each output frame starts with the header. out_sop is on the first header word. Symbol lane 0 is the most significant SYM_W bits of a word, and header symbol 0 is the most significant symbol of hdr_vec.
- R3: The header is taken from hdr_vec when the frame's first input word is offered. Changes to hdr_vec after that word has been accepted do not affect the frame.
- R4: Payload symbols follow the last header symbol in the very next lane, in their input order, with no unused lanes between them.
- R5: On the out_eop word, out_empty = (SPW - (HDR_SYMS + payload symbols) mod SPW) mod SPW, where SPW = DATA_W/SYM_W. The unused lanes are the least significant ones. On every other word out_empty is 0.
- R6: Each frame produces exactly ceil((HDR_SYMS + payload symbols)/SPW) output words. If the remnant of the last input word does not fit, one extra eop word is emitted, and no input is accepted while it is emitted.
- R7: While out_valid is high and out_ready is low, the output word and its flags stay unchanged, and no input word is lost or duplicated.
- R8: When HDR_SYMS is a multiple of SPW, payload words pass through unshifted, and out_empty on the last word equals in_empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_vec | input | HDR_SYMS*SYM_W | Header value, symbol 0 in the most significant bits |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | Input first word of frame |
| in_eop | input | 1 | Input last word of frame |
| in_empty | input | EMPTY_W | Unused least significant symbol lanes on the input eop word |
| in_data | input | DATA_W | Input payload word |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_sop | output | 1 | Output first word of frame |
| out_eop | output | 1 | Output last word of frame |
| out_empty | output | EMPTY_W | Unused least significant symbol lanes on the output eop word |
| out_data | output | DATA_W | Output word |

## Verification
The main instance has six header symbols on four-symbol words, so payload is always shifted by two lanes. Payload lengths are chosen to tell the end-of-frame cases apart:
- a remnant that fits into the last shifted word;
- a remnant that forces an extra flush word;
- a total that fills the last word exactly, so the empty count wraps to zero;
- a one-symbol payload.

A frame whose header vector is inverted after its first word is accepted shows whether the header is latched. A frame that follows immediately afterwards shows whether the new header is taken up. A frame with random output stalls and input gaps shows whether output words are held steady and no input word is lost. A second instance with a word-aligned header shows that payload passes unshifted and that the input empty count is carried through.

// File: rtl/hp_pkg.sv
`timescale 1ns/1ps
package hp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HDR   = 2'd1,
    ST_BODY  = 2'd2,
    ST_FLUSH = 2'd3
  } hp_state_e;

endpackage

// File: rtl/hp_hdr_slicer.sv
`timescale 1ns/1ps
// Selects one whole header word (most significant word first) by index.
module hp_hdr_slicer #(
  parameter int DATA_W = 32,
  parameter int HDR_W  = 48,
  parameter int NFULL  = 1,
  parameter int IW     = 1
) (
  input  logic [HDR_W-1:0]  hdr,
  input  logic [IW-1:0]     idx,
  output logic [DATA_W-1:0] word
);

  generate
    if (NFULL > 0) begin : g_sel
      logic [DATA_W-1:0] words [NFULL];
      for (genvar k = 0; k < NFULL; k++) begin : g_word
        assign words[k] = hdr[HDR_W-1-k*DATA_W -: DATA_W];
      end
      always_comb begin
        word = '0;
        for (int k = 0; k < NFULL; k++) begin
          if (idx == IW'(k)) word = words[k];
        end
      end
    end else begin : g_none
      assign word = '0;
    end
  endgenerate

endmodule

// File: rtl/hp_lane_merge.sv
`timescale 1ns/1ps
// Joins the carried remnant with the leading lanes of the current input word.
module hp_lane_merge #(
  parameter int DATA_W = 32,
  parameter int RES    = 2,
  parameter int CW     = 16
) (
  input  logic [CW-1:0]     carry,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] merged,
  output logic [CW-1:0]     carry_next,
  output logic [DATA_W-1:0] flush_word
);

  generate
    if (RES > 0) begin : g_shift
      assign merged     = {carry, in_data[DATA_W-1 -: DATA_W-CW]};
      assign carry_next = in_data[CW-1:0];
      assign flush_word = {carry, {(DATA_W-CW){1'b0}}};
    end else begin : g_pass
      assign merged     = in_data;
      assign carry_next = '0;
      assign flush_word = '0;
    end
  endgenerate

endmodule

// File: rtl/hp_tail_calc.sv
`timescale 1ns/1ps
// Works out how the frame ends: whether the remnant fits, and both empty counts.
module hp_tail_calc #(
  parameter int SPW = 4,
  parameter int EW  = 2,
  parameter int RES = 2
) (
  input  logic [EW-1:0] in_empty,
  output logic          fits,
  output logic [EW-1:0] last_empty,
  output logic [EW-1:0] flush_empty
);

  localparam int TW = $clog2(2*SPW+1) + 1;

  logic [TW-1:0] valid_syms;
  logic [TW-1:0] total;

  always_comb begin
    valid_syms  = TW'(SPW) - TW'(in_empty);
    total       = valid_syms + TW'(RES);
    fits        = (total <= TW'(SPW));
    last_empty  = EW'(TW'(SPW) - total);
    flush_empty = EW'(TW'(2*SPW) - total);
  end

endmodule

// File: rtl/sym_hdr_prepend.sv
`timescale 1ns/1ps
module sym_hdr_prepend #(
  parameter int DATA_W   = 32,
  parameter int SYM_W    = 8,
  parameter int HDR_SYMS = 6,
  localparam int SPW     = DATA_W / SYM_W,
  localparam int EMPTY_W = (SPW > 1) ? $clog2(SPW) : 1,
  localparam int HDR_W   = HDR_SYMS * SYM_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HDR_W-1:0]   hdr_vec,
  input  logic               in_valid,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic [EMPTY_W-1:0] in_empty,
  input  logic [DATA_W-1:0]  in_data,
  output logic               in_ready,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_sop,
  output logic               out_eop,
  output logic [EMPTY_W-1:0] out_empty,
  output logic [DATA_W-1:0]  out_data
);
  import hp_pkg::*;

  localparam int NFULL = HDR_SYMS / SPW;
  localparam int RES   = HDR_SYMS % SPW;
  localparam int CW    = (RES > 0) ? RES * SYM_W : 1;
  localparam int IW    = (NFULL > 1) ? $clog2(NFULL) : 1;

  hp_state_e          state;
  logic [IW-1:0]      idx;
  logic [HDR_W-1:0]   hreg;
  logic [CW-1:0]      carry;
  logic               sop_pend;
  logic [EMPTY_W-1:0] flush_empty_q;

  logic               ov_q, osop_q, oeop_q;
  logic [EMPTY_W-1:0] oemp_q;
  logic [DATA_W-1:0]  odat_q;

  logic [DATA_W-1:0]  hdr_word, merged, flush_word;
  logic [CW-1:0]      carry_next;
  logic               fits;
  logic [EMPTY_W-1:0] last_empty, flush_empty;
  logic               adv;

  hp_hdr_slicer #(.DATA_W(DATA_W), .HDR_W(HDR_W), .NFULL(NFULL), .IW(IW)) u_slice (
    .hdr(hreg), .idx(idx), .word(hdr_word)
  );

  hp_lane_merge #(.DATA_W(DATA_W), .RES(RES), .CW(CW)) u_merge (
    .carry(carry), .in_data(in_data), .merged(merged),
    .carry_next(carry_next), .flush_word(flush_word)
  );

  hp_tail_calc #(.SPW(SPW), .EW(EMPTY_W), .RES(RES)) u_tail (
    .in_empty(in_empty), .fits(fits), .last_empty(last_empty), .flush_empty(flush_empty)
  );

  assign adv      = !ov_q || out_ready;
  assign in_ready = (state == ST_BODY) && adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      idx           <= '0;
      hreg          <= '0;
      carry         <= '0;
      sop_pend      <= 1'b0;
      flush_empty_q <= '0;
      ov_q          <= 1'b0;
      osop_q        <= 1'b0;
      oeop_q        <= 1'b0;
      oemp_q        <= '0;
      odat_q        <= '0;
    end else begin
      if (adv) ov_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid && in_sop) begin
            hreg     <= hdr_vec;
            idx      <= '0;
            sop_pend <= 1'b1;
            if (NFULL > 0) begin
              state <= ST_HDR;
            end else begin
              state <= ST_BODY;
              carry <= hdr_vec[CW-1:0];
            end
          end
        end
        ST_HDR: begin
          if (adv) begin
            ov_q     <= 1'b1;
            odat_q   <= hdr_word;
            osop_q   <= (idx == '0);
            oeop_q   <= 1'b0;
            oemp_q   <= '0;
            sop_pend <= 1'b0;
            if (idx == IW'(NFULL-1)) begin
              state <= ST_BODY;
              carry <= hreg[CW-1:0];
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_BODY: begin
          if (in_valid && adv) begin
            ov_q     <= 1'b1;
            odat_q   <= merged;
            osop_q   <= sop_pend;
            sop_pend <= 1'b0;
            carry    <= carry_next;
            if (in_eop && fits) begin
              oeop_q <= 1'b1;
              oemp_q <= last_empty;
              state  <= ST_IDLE;
            end else if (in_eop) begin
              oeop_q        <= 1'b0;
              oemp_q        <= '0;
              flush_empty_q <= flush_empty;
              state         <= ST_FLUSH;
            end else begin
              oeop_q <= 1'b0;
              oemp_q <= '0;
            end
          end
        end
        ST_FLUSH: begin
          if (adv) begin
            ov_q   <= 1'b1;
            odat_q <= flush_word;
            osop_q <= 1'b0;
            oeop_q <= 1'b1;
            oemp_q <= flush_empty_q;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = ov_q;
  assign out_sop   = osop_q;
  assign out_eop   = oeop_q;
  assign out_empty = oemp_q;
  assign out_data  = odat_q;

  // A stalled output word must not change.
  assert_hold_under_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop)
                                   && $stable(out_eop) && $stable(out_empty)));

  // A non-final word never reports empty lanes.
  assert_empty_only_on_eop_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_eop) |-> (out_empty == '0));

  // A frame's first word is a header word, so it cannot also close the frame.
  assert_sop_not_eop_R2: assert property (@(posedge clk) disable iff (rst)
    ((NFULL > 0) && out_valid && out_sop) |-> !out_eop);

  // An accepted input eop always yields an output word on the next cycle.
  assert_eop_produces_word_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_eop) |=> out_valid);

endmodule

// File: tb/tb_sym_hdr_prepend.sv
`timescale 1ns/1ps
module tb_sym_hdr_prepend;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  logic        sel = 1'b0;
  logic        b_valid = 1'b0, b_sop = 1'b0, b_eop = 1'b0, b_ordy = 1'b1;
  logic [1:0]  b_empty = '0;
  logic [31:0] b_data = '0;
  logic [63:0] b_hdr = '0;
  bit          stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic rm, ra, vm, va, sm, sa, em, ea;
  logic [1:0]  pm, pa;
  logic [31:0] dm, da;

  sym_hdr_prepend #(.DATA_W(32), .SYM_W(8), .HDR_SYMS(6)) dut (
    .clk(clk), .rst(rst), .hdr_vec(b_hdr[47:0]),
    .in_valid(b_valid & ~sel), .in_sop(b_sop), .in_eop(b_eop), .in_empty(b_empty),
    .in_data(b_data), .in_ready(rm), .out_valid(vm), .out_ready(b_ordy | sel),
    .out_sop(sm), .out_eop(em), .out_empty(pm), .out_data(dm));

  sym_hdr_prepend #(.DATA_W(32), .SYM_W(8), .HDR_SYMS(8)) dut_al (
    .clk(clk), .rst(rst), .hdr_vec(b_hdr),
    .in_valid(b_valid & sel), .in_sop(b_sop), .in_eop(b_eop), .in_empty(b_empty),
    .in_data(b_data), .in_ready(ra), .out_valid(va), .out_ready(b_ordy | ~sel),
    .out_sop(sa), .out_eop(ea), .out_empty(pa), .out_data(da));

  wire        m_rdy = sel ? ra : rm;
  wire        m_val = sel ? va : vm;
  wire        m_sop = sel ? sa : sm;
  wire        m_eop = sel ? ea : em;
  wire [1:0]  m_emp = sel ? pa : pm;
  wire [31:0] m_dat = sel ? da : dm;

  logic [31:0] q_dat[$];
  logic        q_sop[$];
  logic        q_eop[$];
  logic [1:0]  q_emp[$];

  logic        prev_stall = 1'b0;
  logic [31:0] prev_dat = '0;
  int          stall_err = 0;
  int          stall_seen = 0;

  // Monitor: sample away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        stall_seen++;
        if (!(m_val && m_dat == prev_dat)) stall_err++;
      end
      prev_stall <= m_val && !b_ordy && !sel;
      prev_dat   <= m_dat;
      if (m_val && (b_ordy || sel)) begin
        q_dat.push_back(m_dat); q_sop.push_back(m_sop);
        q_eop.push_back(m_eop); q_emp.push_back(m_emp);
      end
    end
  end

  // Output ready pattern.
  initial begin
    forever begin
      @(posedge clk); #2;
      lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b_ordy = stall_mode ? lfsr[0] : 1'b1;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive_frame(int nsym, int seed, logic [63:0] hdr, bit gaps, bit scramble);
    int  nw = (nsym + 3) / 4;
    bit  acc;
    for (int w = 0; w < nw; w++) begin
      logic [31:0] word;
      for (int l = 0; l < 4; l++) begin
        int k = w*4 + l;
        word[31-8*l -: 8] = (k < nsym) ? 8'((seed + k) & 255) : 8'hEE;
      end
      b_data  = word;
      b_valid = 1'b1;
      b_sop   = (w == 0);
      b_eop   = (w == nw-1);
      b_empty = (w == nw-1) ? 2'(nw*4 - nsym) : 2'd0;
      if (w == 0) b_hdr = hdr;
      do begin
        @(negedge clk); acc = m_rdy;
        @(posedge clk); #2;
      end while (!acc);
      if (w == 0 && scramble) b_hdr = ~hdr;
      b_valid = 1'b0; b_sop = 1'b0; b_eop = 1'b0;
      if (gaps && (w % 2 == 1)) begin @(posedge clk); #2; end
    end
  endtask

  task automatic check_frame(int nsym, int seed, logic [63:0] hdr, string hreq);
    int H     = sel ? 8 : 6;
    int total = H + nsym;
    int nw    = (total + 3) / 4;
    int t     = 0;
    while (q_dat.size() < nw && t < 400) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
    chk(q_dat.size() == nw, "R6", "word count", 32'(q_dat.size()), 32'(nw));
    for (int w = 0; w < nw && q_dat.size() > 0; w++) begin
      logic [31:0] got = q_dat.pop_front();
      logic        gs  = q_sop.pop_front();
      logic        ge  = q_eop.pop_front();
      logic [1:0]  gm  = q_emp.pop_front();
      logic [31:0] exp = '0, mask = '0;
      bit has_hdr = 1'b0;
      for (int l = 0; l < 4; l++) begin
        int k = w*4 + l;
        if (k < total) begin
          mask[31-8*l -: 8] = 8'hFF;
          if (k < H) begin
            exp[31-8*l -: 8] = 8'((hdr >> (H*8 - 8 - 8*k)) & 64'hFF);
            has_hdr = 1'b1;
          end else exp[31-8*l -: 8] = 8'((seed + k - H) & 255);
        end
      end
      chk((got & mask) == exp, has_hdr ? hreq : (sel ? "R8" : "R4"), "data", got & mask, exp);
      chk(gs == (w == 0), "R2", "sop", 32'(gs), 32'(w == 0));
      chk(ge == (w == nw-1), "R6", "eop", 32'(ge), 32'(w == nw-1));
      chk(gm == ((w == nw-1) ? 2'(nw*4 - total) : 2'd0), sel ? "R8" : "R5", "empty",
          32'(gm), 32'((w == nw-1) ? nw*4 - total : 0));
    end
    q_dat.delete(); q_sop.delete(); q_eop.delete(); q_emp.delete();
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!m_val && !m_rdy, "R1", "idle in reset", {m_val, m_rdy}, 32'd0);
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    chk(!m_val && !m_rdy, "R1", "idle after reset", {m_val, m_rdy}, 32'd0);
  endtask

  task automatic t_fit;       // remnant fits, empty 1
    drive_frame(9, 16, 64'h0000_A1A2_A3A4_A5A6, 0, 0);
    check_frame(9, 16, 64'h0000_A1A2_A3A4_A5A6, "R2");
  endtask

  task automatic t_flush;     // remnant overflows, extra word (R6)
    drive_frame(7, 48, 64'h0000_B1B2_B3B4_B5B6, 0, 0);
    check_frame(7, 48, 64'h0000_B1B2_B3B4_B5B6, "R2");
  endtask

  task automatic t_exact;     // total fills last word, empty wraps to 0 (R5)
    drive_frame(10, 96, 64'h0000_C1C2_C3C4_C5C6, 0, 0);
    check_frame(10, 96, 64'h0000_C1C2_C3C4_C5C6, "R2");
  endtask

  task automatic t_single;    // one payload symbol
    drive_frame(1, 200, 64'h0000_D1D2_D3D4_D5D6, 0, 0);
    check_frame(1, 200, 64'h0000_D1D2_D3D4_D5D6, "R2");
  endtask

  task automatic t_hdr_latch; // R3: header vector changed mid-frame
    drive_frame(11, 5, 64'h0000_1122_3344_5566, 0, 1);
    check_frame(11, 5, 64'h0000_1122_3344_5566, "R3");
    drive_frame(6, 70, 64'h0000_6655_4433_2211, 0, 0);
    check_frame(6, 70, 64'h0000_6655_4433_2211, "R3");
  endtask

  task automatic t_stall;     // R7: random output stalls and input gaps
    stall_err = 0; stall_seen = 0;
    stall_mode = 1'b1;
    drive_frame(13, 120, 64'h0000_E1E2_E3E4_E5E6, 1, 0);
    check_frame(13, 120, 64'h0000_E1E2_E3E4_E5E6, "R2");
    stall_mode = 1'b0;
    chk(stall_err == 0, "R7", "held under stall", 32'(stall_err), 32'd0);
    chk(stall_seen > 0, "R7", "stalls occurred", 32'(stall_seen), 32'd1);
  endtask

  task automatic t_aligned;   // R8: word-aligned header on second instance
    sel = 1'b1;
    drive_frame(7, 30, 64'hF1F2_F3F4_F5F6_F7F8, 0, 0);
    check_frame(7, 30, 64'hF1F2_F3F4_F5F6_F7F8, "R8");
    sel = 1'b0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_fit();
    t_flush();
    t_exact();
    t_single();
    t_hdr_latch();
    t_stall();
    t_aligned();
    repeat (5) @(posedge clk);
    finish_run();
  end

endmodule